// File: doc/BRIEF.md
# Dual-Clock FIFO with Run-Time Almost-Empty and Almost-Full Thresholds

This block is a first-in first-out buffer for 9-bit words whose producer and consumer run on unrelated clocks. The producer pushes a word on a write-clock edge when its write strobe is LOW and its second enable is HIGH. The consumer pops a word on a read-clock edge when both of its read strobes are LOW. The depth is set by a parameter. The default is kept small enough to elaborate quickly; a production build raises it to 64K words.

Four active-LOW status flags report occupancy: empty, full, almost-empty and almost-full. The empty and almost-empty flags belong to the read domain. The full and almost-full flags belong to the write domain. The almost-empty threshold `n` and the almost-full threshold `m` come from a separate offset block over two parallel ports, and each has its own load strobe in the domain that uses it. Both thresholds return to 7 on reset. The pointers cross between the domains as Gray codes through two-flop synchronisers. A flag may therefore stay asserted a few cycles longer than the true occupancy requires, but it is never released too early.

Top module: `dual_clk_fifo_flags`

## Requirements
- R1: `full_no` is LOW while the FIFO holds DEPTH words. While it is LOW, no word is stored, whatever the write enables are.
- R2: `empty_no` is LOW while the FIFO holds zero words. While it is LOW, no word is popped and `rd_data_o` holds its value, whatever the read enables are.
- R3: A word is stored on a `wclk_i` rising edge only when `wr_en_ni` is 0, `wr_en2_i` is 1 and `full_no` is 1. With `wr_en2_i` at 0, nothing is stored.
- R4: A word is popped on a `rclk_i` rising edge only when `rd_en1_ni` and `rd_en2_ni` are both 0. On that edge `rd_data_o` takes the oldest word. Words leave in the order they were written.
- R5: `almost_empty_no` is LOW when `n` or fewer words are unread and HIGH when `n`+1 or more are unread. It is updated on `rclk_i`.
- R6: `almost_full_no` is LOW when the unread count is at least DEPTH-`m` and HIGH when more than `m` locations are free. It is updated on `wclk_i`.
- R7: Once settled, the flags read `{empty_no, almost_empty_no, almost_full_no, full_no}` by occupancy as follows: 0 gives 0011; 1..n gives 1011; n+1..DEPTH-m-1 gives 1111; DEPTH-m..DEPTH-1 gives 1101; DEPTH gives 1100.
- R8: A HIGH `ae_load_i` on a `rclk_i` edge loads `n` from `ae_off_i`. A HIGH `af_load_i` on a `wclk_i` edge loads `m` from `af_off_i`.
- R9: A LOW on `rst_ni` empties the FIFO. It drives `empty_no` and `almost_empty_no` LOW and `full_no` and `almost_full_no` HIGH, and it restores `n` = `m` = 7.
- R10: Each crossing pointer is a Gray code that changes at most one bit per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active LOW |
| wr_en_ni | input | 1 | Write strobe, active LOW |
| wr_en2_i | input | 1 | Second write enable, active HIGH |
| wr_data_i | input | DW | Write data |
| rd_en1_ni | input | 1 | First read strobe, active LOW |
| rd_en2_ni | input | 1 | Second read strobe, active LOW |
| rd_data_o | output | DW | Registered read data |
| ae_off_i | input | AW | Almost-empty threshold n |
| ae_load_i | input | 1 | Load n (read domain) |
| af_off_i | input | AW | Almost-full threshold m |
| af_load_i | input | 1 | Load m (write domain) |
| empty_no | output | 1 | Empty, active LOW |
| almost_empty_no | output | 1 | Almost-empty, active LOW |
| almost_full_no | output | 1 | Almost-full, active LOW |
| full_no | output | 1 | Full, active LOW |

## Verification
On every cycle, the assertions check four things:
- the write pointer stays put while the FIFO is full, and the read pointer stays put while it is empty;
- full always implies almost-full, and empty always implies almost-empty;
- each Gray pointer moves by at most one bit per clock.

Only the bench scenarios can show the rest:
- the exact occupancy at which each flag switches, and the effect of thresholds loaded at run time;
- that data comes out in first-in first-out order;
- that a reset in mid-run restores the default thresholds.

// File: rtl/fifo_flags_pkg.sv
package fifo_flags_pkg;
  localparam int unsigned DEF_OFFSET = 7;
  localparam int unsigned DEF_DW     = 9;
  localparam int unsigned DEF_AW     = 10;
endpackage

// File: rtl/ptr_sync.sv
module ptr_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/fifo_mem.sv
module fifo_mem #(
  parameter int unsigned DW = 9,
  parameter int unsigned AW = 4,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/fifo_wr_ctl.sv
module fifo_wr_ctl
  import fifo_flags_pkg::*;
#(
  parameter int unsigned AW = 4,
  localparam int unsigned PW = AW + 1
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  logic          wr_en_ni,
  input  logic          wr_en2_i,
  input  logic [PW-1:0] rgray_sync_i,
  input  logic [AW-1:0] af_off_i,
  input  logic          af_load_i,
  output logic [PW-1:0] wgray_o,
  output logic [AW-1:0] waddr_o,
  output logic          we_o,
  output logic          full_no,
  output logic          almost_full_no
);
  localparam logic [PW-1:0] DEPTH = PW'(1) << AW;

  logic [PW-1:0] wbin_q, wbin_nxt, rbin_s, cnt_nxt;
  logic [AW-1:0] m_q;
  logic          wfire;

  always_comb begin
    rbin_s[PW-1] = rgray_sync_i[PW-1];
    for (int i = PW - 2; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rgray_sync_i[i];
  end

  assign wfire    = !wr_en_ni && wr_en2_i && full_no;
  assign wbin_nxt = wbin_q + PW'(wfire);
  assign cnt_nxt  = wbin_nxt - rbin_s;
  assign we_o     = wfire;
  assign waddr_o  = wbin_q[AW-1:0];

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q         <= '0;
      wgray_o        <= '0;
      full_no        <= 1'b1;
      almost_full_no <= 1'b1;
      m_q            <= AW'(DEF_OFFSET);
    end else begin
      wbin_q         <= wbin_nxt;
      wgray_o        <= wbin_nxt ^ (wbin_nxt >> 1);
      full_no        <= (cnt_nxt != DEPTH);
      almost_full_no <= (cnt_nxt < (DEPTH - {1'b0, m_q}));
      if (af_load_i) m_q <= af_off_i;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !full_no |=> $stable(wbin_q)); // R1
  AST_FULL_IN_AF: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !full_no |-> !almost_full_no); // R7
  AST_WGRAY_STEP: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $onehot0(wgray_o ^ $past(wgray_o))); // R10
endmodule

// File: rtl/fifo_rd_ctl.sv
module fifo_rd_ctl
  import fifo_flags_pkg::*;
#(
  parameter int unsigned AW = 4,
  localparam int unsigned PW = AW + 1
) (
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          rd_en1_ni,
  input  logic          rd_en2_ni,
  input  logic [PW-1:0] wgray_sync_i,
  input  logic [AW-1:0] ae_off_i,
  input  logic          ae_load_i,
  output logic [PW-1:0] rgray_o,
  output logic [AW-1:0] raddr_o,
  output logic          re_o,
  output logic          empty_no,
  output logic          almost_empty_no
);
  logic [PW-1:0] rbin_q, rbin_nxt, wbin_s, cnt_nxt;
  logic [AW-1:0] n_q;
  logic          rfire;

  always_comb begin
    wbin_s[PW-1] = wgray_sync_i[PW-1];
    for (int i = PW - 2; i >= 0; i--) wbin_s[i] = wbin_s[i+1] ^ wgray_sync_i[i];
  end

  assign rfire    = !rd_en1_ni && !rd_en2_ni && empty_no;
  assign rbin_nxt = rbin_q + PW'(rfire);
  assign cnt_nxt  = wbin_s - rbin_nxt;
  assign re_o     = rfire;
  assign raddr_o  = rbin_q[AW-1:0];

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q          <= '0;
      rgray_o         <= '0;
      empty_no        <= 1'b0;
      almost_empty_no <= 1'b0;
      n_q             <= AW'(DEF_OFFSET);
    end else begin
      rbin_q          <= rbin_nxt;
      rgray_o         <= rbin_nxt ^ (rbin_nxt >> 1);
      empty_no        <= (cnt_nxt != '0);
      almost_empty_no <= (cnt_nxt > {1'b0, n_q});
      if (ae_load_i) n_q <= ae_off_i;
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !empty_no |=> $stable(rbin_q)); // R2
  AST_EMPTY_IN_AE: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !empty_no |-> !almost_empty_no); // R7
  AST_RGRAY_STEP: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $onehot0(rgray_o ^ $past(rgray_o))); // R10
endmodule

// File: rtl/dual_clk_fifo_flags.sv
module dual_clk_fifo_flags
  import fifo_flags_pkg::*;
#(
  parameter int unsigned DW = DEF_DW,
  parameter int unsigned AW = DEF_AW
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          wr_en_ni,
  input  logic          wr_en2_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en1_ni,
  input  logic          rd_en2_ni,
  output logic [DW-1:0] rd_data_o,
  input  logic [AW-1:0] ae_off_i,
  input  logic          ae_load_i,
  input  logic [AW-1:0] af_off_i,
  input  logic          af_load_i,
  output logic          empty_no,
  output logic          almost_empty_no,
  output logic          almost_full_no,
  output logic          full_no
);
  localparam int unsigned PW = AW + 1;

  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0] waddr, raddr;
  logic          we, re;

  fifo_wr_ctl #(.AW(AW)) u_wr (
    .wclk_i, .rst_ni, .wr_en_ni, .wr_en2_i,
    .rgray_sync_i(rgray_s), .af_off_i, .af_load_i,
    .wgray_o(wgray), .waddr_o(waddr), .we_o(we),
    .full_no, .almost_full_no
  );

  fifo_rd_ctl #(.AW(AW)) u_rd (
    .rclk_i, .rst_ni, .rd_en1_ni, .rd_en2_ni,
    .wgray_sync_i(wgray_s), .ae_off_i, .ae_load_i,
    .rgray_o(rgray), .raddr_o(raddr), .re_o(re),
    .empty_no, .almost_empty_no
  );

  ptr_sync #(.W(PW)) u_w2r (.clk_i(rclk_i), .rst_ni, .d_i(wgray), .q_o(wgray_s));
  ptr_sync #(.W(PW)) u_r2w (.clk_i(wclk_i), .rst_ni, .d_i(rgray), .q_o(rgray_s));

  fifo_mem #(.DW(DW), .AW(AW)) u_mem (
    .wclk_i, .we_i(we), .waddr_i(waddr), .wdata_i(wr_data_i),
    .rclk_i, .rst_ni, .re_i(re), .raddr_i(raddr), .rdata_o(rd_data_o)
  );

  AST_RD_HOLD: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rd_en1_ni || rd_en2_ni) |=> $stable(rd_data_o)); // R4
endmodule

// File: tb/dual_clk_fifo_flags_test.sv
module dual_clk_fifo_flags_test;
  localparam int DW = 9;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic wclk = 0, rclk = 0, rst_ni = 0;
  logic wr_en_ni = 1, wr_en2_i = 1, rd_en1_ni = 1, rd_en2_ni = 1;
  logic [DW-1:0] wr_data_i = '0, rd_data_o;
  logic [AW-1:0] ae_off_i = '0, af_off_i = '0;
  logic ae_load_i = 0, af_load_i = 0;
  logic empty_no, almost_empty_no, almost_full_no, full_no;

  always #2.5 wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  dual_clk_fifo_flags #(.DW(DW), .AW(AW)) uut (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni, .wr_en_ni, .wr_en2_i, .wr_data_i,
    .rd_en1_ni, .rd_en2_ni, .rd_data_o, .ae_off_i, .ae_load_i, .af_off_i,
    .af_load_i, .empty_no, .almost_empty_no, .almost_full_no, .full_no
  );

  int checks = 0, errors = 0;
  int q[$];
  int wval = 1;
  logic [DW-1:0] last = '0;

  // op: 1 write, 0 read; exp = {empty_no, almost_empty_no, almost_full_no, full_no}
  localparam int          N_STEP = 8;
  localparam int          T_OP  [N_STEP] = '{1, 1, 1, 1, 1, 0, 0, 0};
  localparam int          T_N   [N_STEP] = '{1, 7, 1, 7, 3, 8, 8, 2};
  localparam logic [3:0]  T_EXP [N_STEP] = '{4'b1011, 4'b1111, 4'b1101, 4'b1100,
                                             4'b1100, 4'b1111, 4'b0011, 4'b0011};

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic flags(input string tag, input logic [3:0] exp);
    chk(tag, {empty_no, almost_empty_no, almost_full_no, full_no}, exp);
  endtask

  task automatic settle();
    repeat (6) @(negedge wclk);
    repeat (6) @(negedge rclk);
  endtask

  task automatic writes(input int k);
    @(negedge wclk);
    wr_en_ni = 0; wr_en2_i = 1;
    for (int i = 0; i < k; i++) begin
      wr_data_i = DW'(wval);
      @(negedge wclk);
      if (q.size() < DEPTH) q.push_back(wval);
      wval++;
    end
    wr_en_ni = 1;
  endtask

  task automatic reads(input int k);
    @(negedge rclk);
    rd_en1_ni = 0; rd_en2_ni = 0;
    for (int i = 0; i < k; i++) begin
      @(negedge rclk);
      if (q.size() > 0) last = DW'(q.pop_front());
      chk("R4 read data / R2 hold", rd_data_o, last);
    end
    rd_en1_ni = 1; rd_en2_ni = 1;
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #23 rst_ni = 1;
    settle();
    flags("R9 reset flags", 4'b0011);

    for (int s = 0; s < N_STEP; s++) begin
      if (T_OP[s] == 1) writes(T_N[s]); else reads(T_N[s]);
      settle();
      flags($sformatf("R7 table step %0d (R1 R2 R5 R6)", s), T_EXP[s]);
    end

    // R3: second write enable low blocks writes
    @(negedge wclk); wr_en_ni = 0; wr_en2_i = 0; wr_data_i = 9'h1AA;
    repeat (3) @(negedge wclk);
    wr_en_ni = 1; wr_en2_i = 1;
    settle();
    flags("R3 no write with second enable low", 4'b0011);

    // R4: a single read strobe does not pop
    writes(2);
    settle();
    @(negedge rclk); rd_en1_ni = 0; rd_en2_ni = 1;
    repeat (3) @(negedge rclk);
    chk("R4 single strobe holds data", rd_data_o, last);
    rd_en1_ni = 1;
    settle();
    flags("R4 single strobe leaves occupancy", 4'b1011);
    reads(2);
    settle();
    flags("R4 drained", 4'b0011);

    // R8: load n=2, m=3
    @(negedge rclk); ae_off_i = 2; ae_load_i = 1;
    @(negedge rclk); ae_load_i = 0;
    @(negedge wclk); af_off_i = 3; af_load_i = 1;
    @(negedge wclk); af_load_i = 0;
    writes(2); settle();
    flags("R8 n=2 occupancy 2", 4'b1011);
    writes(1); settle();
    flags("R8 n=2 occupancy 3 (R5)", 4'b1111);
    writes(9); settle();
    flags("R8 m=3 occupancy 12", 4'b1111);
    writes(1); settle();
    flags("R8 m=3 occupancy 13 (R6)", 4'b1101);

    // R9: mid-run reset clears contents and restores defaults
    @(negedge wclk); rst_ni = 0;
    repeat (3) @(negedge rclk);
    chk("R9 reset empty", empty_no, 0);
    chk("R9 reset full", full_no, 1);
    #1 rst_ni = 1;
    q.delete();
    last = '0;
    settle();
    flags("R9 post-reset flags", 4'b0011);
    writes(3); settle();
    flags("R9 default n restored", 4'b1011);
    reads(3); settle();
    flags("R9 drained after reset", 4'b0011);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule